// File: doc/BRIEF.md
# Serial Delay-Code Loader for a Dual-Channel Delay Line

This block programs the delay settings of a two-channel delay line over a three-wire serial link. A host drives a data wire, a shift clock and a load strobe. Each rising edge of the shift clock moves one bit into a 20-bit scan chain. The load strobe passes the chain contents into two 10-bit delay-code registers, one for each channel. The bit that falls off the far end of the chain is driven on a serial output. Wiring that output to the data wire of a second loader lets one host program several devices in a row.

All three serial wires are oversampled by the block's own clock. Each wire passes through a small synchroniser, and edges are found by comparing successive samples. While the load strobe is high, the code registers follow the chain on every cycle. The value present at the rising edge of the strobe is therefore committed, and any shifting done while the strobe stays high reaches the codes at once.

Each channel also has an active-low enable. When the enable is deasserted, the channel's true output is forced low and its complement output is forced high. For checking, each channel reports its nominal delay in picoseconds. This value is derived from its code: 2000 ps at code 0, plus 5 ps per count.

Top module: `dly_prog_loader`

## Requirements
- R1: A synchronous reset clears the scan chain and both code registers to zero. After reset, `serOut` is 0 and both delay outputs read 2000.
- R2: Each rising edge of `serClk` shifts `serData` into the chain, with new bits entering at the top. The first bit sent therefore travels to the far end. After 20 edges, bits 1 to 10 sent form `codeA`, least significant bit first, and bits 11 to 20 sent form `codeB`, least significant bit first. The effect appears within 4 clock cycles of the edge.
- R3: While `serLoad` is low, shifting does not change `codeA` or `codeB`.
- R4: While `serLoad` is high, both codes follow the chain. This includes bits shifted in during that time. After `serLoad` rises, the codes equal the chain contents at that moment.
- R5: `serOut` always shows the bit at the far end of the chain. This is the bit that the next shift will expel, so previously loaded bits leave in the order they were sent.
- R6: When more than 20 bits are shifted before a load, the codes take the last 20 bits sent.
- R7: When an enable input is 1, that channel's `q` output is 0 and its `qNeg` output is 1. When the enable is 0, `q` equals the channel input and `qNeg` is its inverse. The two channels act independently.
- R8: `delayPsA` and `delayPsB` equal 2000 + 5 × code, so they span 2000 to 7115.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial wires |
| rst | input | 1 | Synchronous reset, active high |
| serClk | input | 1 | Serial shift clock, sampled; its rising edge shifts |
| serData | input | 1 | Serial data bit |
| serLoad | input | 1 | Load strobe; codes follow the chain while high |
| serOut | output | 1 | Far-end bit of the chain, for cascading |
| enANeg | input | 1 | Channel A enable, active low |
| enBNeg | input | 1 | Channel B enable, active low |
| inA | input | 1 | Channel A signal input |
| inB | input | 1 | Channel B signal input |
| qA | output | 1 | Channel A true output |
| qANeg | output | 1 | Channel A complement output |
| qB | output | 1 | Channel B true output |
| qBNeg | output | 1 | Channel B complement output |
| codeA | output | 10 | Channel A delay code |
| codeB | output | 10 | Channel B delay code |
| delayPsA | output | 16 | Channel A nominal delay in ps |
| delayPsB | output | 16 | Channel B nominal delay in ps |

## Verification
The assertions take for granted that `serClk` is much slower than `clk`. Each high and low phase of `serClk` must last longer than the synchroniser depth plus one cycle, so that one shift edge never produces two back-to-back shift strobes. They also assume `serData` is steady around each rising shift edge, so that data and clock leave the synchroniser in step. The stimulus keeps to these limits by holding every phase of `serClk` and `serLoad` for six or more clock cycles. It changes `serData` only while `serClk` is low.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;
  // strobes from the serial control to the code datapath
  typedef struct packed {
    logic shiftEn;   // one-cycle pulse per rising serial clock
    logic loadOpen;  // load latch transparent
    logic loadRise;  // first cycle of an open load
  } dly_strobe_t;
endpackage

// File: rtl/dly_serial_ctrl.sv
module dly_serial_ctrl
  import dly_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  output dly_strobe_t strobe,
  output logic        dataBit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkPipe, dataPipe, loadPipe;
  logic clkLast, loadLast;
  logic clkNow, loadNow;

  assign clkNow  = clkPipe[TOP];
  assign loadNow = loadPipe[TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPipe  <= '0;
      dataPipe <= '0;
      loadPipe <= '0;
      clkLast  <= 1'b0;
      loadLast <= 1'b0;
    end else begin
      clkPipe  <= SYNC_STAGES'({clkPipe, serClk});
      dataPipe <= SYNC_STAGES'({dataPipe, serData});
      loadPipe <= SYNC_STAGES'({loadPipe, serLoad});
      clkLast  <= clkNow;
      loadLast <= loadNow;
    end
  end

  always_comb begin
    strobe.shiftEn  = clkNow & ~clkLast;
    strobe.loadOpen = loadNow;
    strobe.loadRise = loadNow & ~loadLast;
    dataBit         = dataPipe[TOP];
  end

  // R2: a slow serial clock yields isolated shift pulses
  p_shift_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftEn |=> !strobe.shiftEn);
endmodule

// File: rtl/dly_code_path.sv
module dly_code_path
  import dly_prog_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int NUM_CH  = 2,
  parameter int PS_W    = 16,
  parameter int BASE_PS = 2000,
  parameter int STEP_PS = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dly_strobe_t              strobe,
  input  logic                     dataBit,
  output logic                     chainOut,
  output logic [NUM_CH*CODE_W-1:0] codeFlat,
  output logic [NUM_CH*PS_W-1:0]   delayFlat
);
  localparam int CHAIN_W = NUM_CH * CODE_W;
  localparam int MAX_PS  = BASE_PS + STEP_PS * ((1 << CODE_W) - 1);

  logic [CHAIN_W-1:0] chain;

  // new bits enter at the top; the oldest bit sits at index 0
  always_ff @(posedge clk) begin
    if (rst)                 chain <= '0;
    else if (strobe.shiftEn) chain <= {dataBit, chain[CHAIN_W-1:1]};
  end

  assign chainOut = chain[0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] codeReg;
    logic [PS_W-1:0]   delayPs;

    always_ff @(posedge clk) begin
      if (rst)                  codeReg <= '0;
      else if (strobe.loadOpen) codeReg <= chain[ch*CODE_W +: CODE_W];
    end

    assign delayPs = PS_W'(BASE_PS) + PS_W'(STEP_PS) * PS_W'(codeReg);
    assign codeFlat[ch*CODE_W +: CODE_W] = codeReg;
    assign delayFlat[ch*PS_W +: PS_W]    = delayPs;

    // R8: nominal delay stays inside the programmable span
    p_delay_span_r8: assert property (@(posedge clk) disable iff (rst)
      (int'(delayPs) >= BASE_PS) && (int'(delayPs) <= MAX_PS));
  end

  // R2: chain moves only on a shift pulse
  p_chain_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(chain));

  // R5: after a shift the cascade output carries the former second bit
  p_serout_step_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftEn |=> chainOut == $past(chain[1]));

  // R3: codes frozen while the load latch is closed
  p_codes_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadOpen |=> $stable(codeFlat));

  // R4: opening the latch commits the chain contents
  p_commit_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.loadRise |=> codeFlat == $past(chain));
endmodule

// File: rtl/dly_chan_gate.sv
module dly_chan_gate (
  input  logic clk,
  input  logic rst,
  input  logic enNeg,
  input  logic dIn,
  output logic q,
  output logic qNeg
);
  always_comb begin
    q    = dIn & ~enNeg;
    qNeg = ~q;
  end

  // R7: disabled channel parks low on the true side
  p_forced_low_r7: assert property (@(posedge clk) disable iff (rst)
    enNeg |-> (!q && qNeg));
endmodule

// File: rtl/dly_prog_loader.sv
module dly_prog_loader
  import dly_prog_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int PS_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_PS     = 2000,
  parameter int STEP_PS     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  output logic              serOut,
  input  logic              enANeg,
  input  logic              enBNeg,
  input  logic              inA,
  input  logic              inB,
  output logic              qA,
  output logic              qANeg,
  output logic              qB,
  output logic              qBNeg,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB,
  output logic [PS_W-1:0]   delayPsA,
  output logic [PS_W-1:0]   delayPsB
);
  localparam int NUM_CH = 2;

  dly_strobe_t strobe;
  logic        dataBit;
  logic [NUM_CH*CODE_W-1:0] codeFlat;
  logic [NUM_CH*PS_W-1:0]   delayFlat;
  logic [NUM_CH-1:0] enVec, inVec, qVec, qNegVec;

  dly_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .strobe(strobe), .dataBit(dataBit));

  dly_code_path #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .PS_W(PS_W),
    .BASE_PS(BASE_PS), .STEP_PS(STEP_PS)
  ) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .dataBit(dataBit),
    .chainOut(serOut), .codeFlat(codeFlat), .delayFlat(delayFlat));

  assign enVec = {enBNeg, enANeg};
  assign inVec = {inB, inA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
    dly_chan_gate u_gate (
      .clk(clk), .rst(rst), .enNeg(enVec[ch]), .dIn(inVec[ch]),
      .q(qVec[ch]), .qNeg(qNegVec[ch]));
  end

  assign qA       = qVec[0];
  assign qANeg    = qNegVec[0];
  assign qB       = qVec[1];
  assign qBNeg    = qNegVec[1];
  assign codeA    = codeFlat[CODE_W-1:0];
  assign codeB    = codeFlat[2*CODE_W-1:CODE_W];
  assign delayPsA = delayFlat[PS_W-1:0];
  assign delayPsB = delayFlat[2*PS_W-1:PS_W];
endmodule

// File: tb/dly_prog_loader_bench.sv
module dly_prog_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 200000;

  localparam int K_CODEA = 0, K_CODEB = 1, K_SOUT = 2, K_QA = 3, K_QAN = 4,
                 K_QB = 5, K_QBN = 6, K_DLYA = 7, K_DLYB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic enANeg = 1'b0, enBNeg = 1'b0, inA = 1'b0, inB = 1'b0;
  logic serOut, qA, qANeg, qB, qBNeg;
  logic [9:0]  codeA, codeB;
  logic [15:0] delayPsA, delayPsB;

  int total = 0, bad = 0;
  bit finished = 0;
  longint cycleCnt = 0;

  // scoreboard queues
  int          qKind[$];
  logic [31:0] qExp[$];
  longint      qDue[$];
  string       qTag[$];

  // spec-level model of chain and committed codes
  logic [19:0] mChain = '0;
  logic [9:0]  mCodeA = '0, mCodeB = '0;

  dly_prog_loader u_dly_prog_loader (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serOut(serOut), .enANeg(enANeg), .enBNeg(enBNeg),
    .inA(inA), .inB(inB), .qA(qA), .qANeg(qANeg), .qB(qB), .qBNeg(qBNeg),
    .codeA(codeA), .codeB(codeB), .delayPsA(delayPsA), .delayPsB(delayPsB));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_CODEA: return 32'(codeA);
      K_CODEB: return 32'(codeB);
      K_SOUT:  return 32'(serOut);
      K_QA:    return 32'(qA);
      K_QAN:   return 32'(qANeg);
      K_QB:    return 32'(qB);
      K_QBN:   return 32'(qBNeg);
      K_DLYA:  return 32'(delayPsA);
      default: return 32'(delayPsB);
    endcase
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (qDue.size() > 0 && qDue[0] <= cycleCnt) begin
      automatic int k = qKind.pop_front();
      automatic logic [31:0] e = qExp.pop_front();
      automatic string t = qTag.pop_front();
      automatic logic [31:0] a = actual(k);
      void'(qDue.pop_front());
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", t, k, a, e);
      end
    end
  end

  task automatic chk(int kind, logic [31:0] e, string tag);
    qKind.push_back(kind);
    qExp.push_back(e);
    qDue.push_back(cycleCnt + 1);
    qTag.push_back(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_codes(string tag);
    chk(K_CODEA, 32'(mCodeA), tag);
    chk(K_CODEB, 32'(mCodeB), tag);
  endtask

  task automatic chk_delays(string tag);
    chk(K_DLYA, 2000 + 5 * int'(mCodeA), tag);
    chk(K_DLYB, 2000 + 5 * int'(mCodeB), tag);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    serData = b;
    repeat (HALF) @(negedge clk);
    serClk = 1'b1;
    mChain = {b, mChain[19:1]};
    if (serLoad) begin
      mCodeA = mChain[9:0];
      mCodeB = mChain[19:10];
    end
    repeat (HALF) @(negedge clk);
    serClk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_word(logic [9:0] a, logic [9:0] b);
    for (int i = 0; i < 10; i++) send_bit(a[i]);
    for (int i = 0; i < 10; i++) send_bit(b[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    serLoad = 1'b1;
    mCodeA  = mChain[9:0];
    mCodeB  = mChain[19:10];
    repeat (8) @(negedge clk);
    serLoad = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(K_CODEA, 0, "R1");
    chk(K_CODEB, 0, "R1");
    chk(K_SOUT, 0, "R1");
    chk(K_DLYA, 2000, "R1");
    chk(K_DLYB, 2000, "R1");

    // R3: a full word shifted with load low leaves codes at zero
    send_word(10'h2A5, 10'h13C);
    chk_codes("R3");
    // R5: first bit sent (DA0 = 1) now at the far end
    chk(K_SOUT, 1, "R5");

    // R2: load commits the word in A-then-B, LSB-first order
    pulse_load();
    chk(K_CODEA, 10'h2A5, "R2");
    chk(K_CODEB, 10'h13C, "R2");
    chk_delays("R8");

    // R5: cascade output replays the old word bit by bit
    for (int i = 0; i < 20; i++) begin
      send_bit(logic'(i % 3 == 0));
      chk(K_SOUT, 32'(mChain[0]), "R5");
    end
    chk_codes("R3");

    // R6: 25 bits before load, last 20 win
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_word(10'h155, 10'h2AA);
    pulse_load();
    chk(K_CODEA, 10'h155, "R6");
    chk(K_CODEB, 10'h2AA, "R6");

    // R4: shifting while load is high passes straight to the codes
    @(negedge clk);
    serLoad = 1'b1;
    mCodeA = mChain[9:0];
    mCodeB = mChain[19:10];
    repeat (8) @(negedge clk);
    send_bit(1'b1);
    chk_codes("R4");
    send_bit(1'b0);
    chk_codes("R4");
    serLoad = 1'b0;
    repeat (8) @(negedge clk);
    send_bit(1'b1);
    send_bit(1'b1);
    chk_codes("R3");

    // R8: code extremes
    send_word(10'h3FF, 10'h000);
    pulse_load();
    chk(K_DLYA, 7115, "R8");
    chk(K_DLYB, 2000, "R8");

    // R7: enable gating, channels independent
    enANeg = 1'b1; inA = 1'b1; enBNeg = 1'b0; inB = 1'b1;
    chk(K_QA, 0, "R7");
    chk(K_QAN, 1, "R7");
    chk(K_QB, 1, "R7");
    chk(K_QBN, 0, "R7");
    enANeg = 1'b0; enBNeg = 1'b1;
    chk(K_QA, 1, "R7");
    chk(K_QAN, 0, "R7");
    chk(K_QB, 0, "R7");
    chk(K_QBN, 1, "R7");
    inA = 1'b0;
    chk(K_QA, 0, "R7");
    chk(K_QAN, 1, "R7");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule